// File: doc/BRIEF.md
# String Store Byte Sequencer

This block carries out the multi-cycle store-string operation inside a load/store unit. A single start pulse hands it everything it needs: the first source register index, the base register index and its value, the index register value, and the fixed-point exception register, whose low seven bits give the byte count. The block forms the effective address from these. It then streams the requested number of bytes to a byte-wide memory write port, one byte per accepted handshake. The bytes are taken from consecutive general registers through a register-file read port.

Each register contributes up to four bytes of its 32-bit word, most significant byte first. The register index wraps from the last register back to register 0, and a partially used final register leaves its trailing bytes unwritten. Before the first byte goes out, the block issues invalidation pulses for the reservation lines that the store touches. This happens only when reservation tracking is enabled and has active holders. After the final byte it raises a one-cycle done pulse.

Top module: `sss_string_store`

## Requirements
- R1: The byte count is `xer_i[6:0]` (0 to 127). Bits above bit 6 of `xer_i` have no effect on the transfer.
- R2: A start with a byte count of zero makes no memory write and no invalidation. It raises `done_o` in the cycle after the start edge, and `busy_o` stays low.
- R3: The first byte is written at `index_val_i + base_val_i`, or at `index_val_i` alone when `base_idx_i` is 0.
- R4: Bytes are taken from bits [31:0] of each source register in the order [31:24], [23:16], [15:8], [7:0].
- R5: The first source register is `src_idx_i`. After four bytes the read index steps by one modulo 32, so register 31 is followed by register 0.
- R6: Exactly as many bytes are written as the count says. The unused low-order bytes of a partial final register are not written.
- R7: Each byte address is the previous one plus one, wrapping modulo 2^32.
- R8: The invalidation pulses are gated. When `resv_en_i` and `resv_active_i` are both high at start and the count is nonzero, the block invalidates the line of the first byte. It also invalidates the line of the last byte (start address + count - 1) when that line differs from the first. A line is the byte address with its low 7 bits cleared. With either gate input low, no invalidation is issued.
- R9: Every invalidation pulse comes before the first byte write of the same transfer.
- R10: While `mem_valid_o` is high and `mem_ready_i` is low, the next cycle keeps `mem_valid_o` high with the same address and data.
- R11: A start pulse while `busy_o` is high is ignored, and the transfer in progress continues unchanged.
- R12: `done_o` is a one-cycle pulse. For a nonzero count it appears in the cycle after the edge that accepts the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| src_idx_i | input | 5 | First source register index |
| base_idx_i | input | 5 | Base register index, 0 means literal zero |
| base_val_i | input | 32 | Base register value |
| index_val_i | input | 32 | Index register value |
| xer_i | input | 32 | Exception register, low 7 bits are the byte count |
| resv_en_i | input | 1 | Reservation tracking enabled |
| resv_active_i | input | 1 | Reservation tracking has active holders |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data for `rf_raddr_o`, same cycle |
| mem_valid_o | output | 1 | Byte write request |
| mem_addr_o | output | 32 | Byte write address |
| mem_data_o | output | 8 | Byte write data |
| mem_ready_i | input | 1 | Memory accepts the byte on this edge |
| inv_valid_o | output | 1 | Reservation-line invalidation pulse |
| inv_line_o | output | 32 | Line address to invalidate |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs. The register file answers a read index combinationally within the same cycle. `start_i` is meaningful only when sampled with `busy_o` low. `mem_ready_i` may stall for any number of cycles but is eventually given. The bench keeps to this with a register-file model that returns `regs[rf_raddr_o]` without delay and start pulses of one cycle. Ready is driven from a fair random coin or held high, so every stall ends. A deliberate start during a busy transfer tests that such a pulse leaves the transfer alone.

// File: rtl/sss_pkg.sv
// Package: shared types of the string store sequencer.
// Assumes: nothing; holds the control state encoding only.
package sss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INV_FIRST,
        ST_INV_LAST,
        ST_LOAD,
        ST_WRITE
    } sss_state_e;
endpackage

// File: rtl/sss_addr_gen.sv
// Module: effective address and reservation-line computation.
// Forms the start address from index plus optional base, and the line
// addresses of the first and last byte of the transfer.
// Assumes: count is nonzero when the line outputs are used.
module sss_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 7,
    parameter int LINE_BYTES = 128
) (
    input  logic              base_is_zero_i,
    input  logic [ADDR_W-1:0] base_val_i,
    input  logic [ADDR_W-1:0] index_val_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] first_line_o,
    output logic [ADDR_W-1:0] last_line_o,
    output logic              two_lines_o
);
    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_SH) - ADDR_W'(1));

    logic [ADDR_W-1:0] last_byte;

    // Address arithmetic for the transfer window.
    always_comb begin
        ea_o         = index_val_i + (base_is_zero_i ? '0 : base_val_i);
        last_byte    = ea_o + ADDR_W'(count_i) - ADDR_W'(1);
        first_line_o = ea_o & LINE_MASK;
        last_line_o  = last_byte & LINE_MASK;
        two_lines_o  = (first_line_o != last_line_o);
    end
endmodule

// File: rtl/sss_byte_lane.sv
// Module: big-endian byte selector.
// Picks byte sel of a word, where sel 0 is the most significant byte.
// Assumes: sel is below WORD_BYTES.
module sss_byte_lane #(
    parameter int WORD_BYTES = 4
) (
    input  logic [8*WORD_BYTES-1:0]         word_i,
    input  logic [$clog2(WORD_BYTES)-1:0]   sel_i,
    output logic [7:0]                      byte_o
);
    localparam int BSEL_W = $clog2(WORD_BYTES);

    // Multiplexer over the byte lanes, highest lane first.
    always_comb begin
        byte_o = '0;
        for (int k = 0; k < WORD_BYTES; k++) begin
            if (sel_i == BSEL_W'(k))
                byte_o = word_i[8*(WORD_BYTES-1-k) +: 8];
        end
    end
endmodule

// File: rtl/sss_string_store.sv
// Module: store-string byte sequencer (top).
// On an idle start it latches the operands and optionally emits one or two
// reservation-line invalidations. It then loads each source register and
// writes its bytes one per handshake, and pulses done at the end.
// Assumes: rf_rdata_i answers rf_raddr_o in the same cycle; the register
// file does not change during a transfer except as the caller intends.
module sss_string_store #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int NREG       = 32,
    parameter int CNT_W      = 7,
    parameter int XER_W      = 32,
    parameter int LINE_BYTES = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [$clog2(NREG)-1:0]   src_idx_i,
    input  logic [$clog2(NREG)-1:0]   base_idx_i,
    input  logic [ADDR_W-1:0]         base_val_i,
    input  logic [ADDR_W-1:0]         index_val_i,
    input  logic [XER_W-1:0]          xer_i,
    input  logic                      resv_en_i,
    input  logic                      resv_active_i,
    output logic [$clog2(NREG)-1:0]   rf_raddr_o,
    input  logic [8*WORD_BYTES-1:0]   rf_rdata_i,
    output logic                      mem_valid_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic [7:0]                mem_data_o,
    input  logic                      mem_ready_i,
    output logic                      inv_valid_o,
    output logic [ADDR_W-1:0]         inv_line_o,
    output logic                      busy_o,
    output logic                      done_o
);
    import sss_pkg::*;

    localparam int REG_W  = $clog2(NREG);
    localparam int BSEL_W = $clog2(WORD_BYTES);
    localparam int WORD_W = 8 * WORD_BYTES;

    sss_state_e          state_q;
    logic [REG_W-1:0]    src_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [CNT_W-1:0]    remain_q;
    logic [BSEL_W-1:0]   bsel_q;
    logic [WORD_W-1:0]   word_q;
    logic [ADDR_W-1:0]   first_line_q;
    logic [ADDR_W-1:0]   last_line_q;
    logic                two_q;
    logic                done_q;

    logic [CNT_W-1:0]    count;
    logic                xer_hi_unused;
    logic                accept;
    logic [ADDR_W-1:0]   ea;
    logic [ADDR_W-1:0]   first_line;
    logic [ADDR_W-1:0]   last_line;
    logic                two_lines;
    logic [7:0]          lane_byte;

    assign count         = xer_i[CNT_W-1:0];
    assign xer_hi_unused = ^xer_i[XER_W-1:CNT_W];
    assign accept        = start_i && (state_q == ST_IDLE);

    sss_addr_gen #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .LINE_BYTES (LINE_BYTES)
    ) i_addr_gen (
        .base_is_zero_i (base_idx_i == '0),
        .base_val_i     (base_val_i),
        .index_val_i    (index_val_i),
        .count_i        (count),
        .ea_o           (ea),
        .first_line_o   (first_line),
        .last_line_o    (last_line),
        .two_lines_o    (two_lines)
    );

    sss_byte_lane #(
        .WORD_BYTES (WORD_BYTES)
    ) i_byte_lane (
        .word_i (word_q),
        .sel_i  (bsel_q),
        .byte_o (lane_byte)
    );

    // Control sequencer: invalidations, register loads and byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            src_q        <= '0;
            addr_q       <= '0;
            remain_q     <= '0;
            bsel_q       <= '0;
            word_q       <= '0;
            first_line_q <= '0;
            last_line_q  <= '0;
            two_q        <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        src_q        <= src_idx_i;
                        addr_q       <= ea;
                        remain_q     <= count;
                        first_line_q <= first_line;
                        last_line_q  <= last_line;
                        two_q        <= two_lines;
                        if (count == '0)
                            done_q <= 1'b1;
                        else if (resv_en_i && resv_active_i)
                            state_q <= ST_INV_FIRST;
                        else
                            state_q <= ST_LOAD;
                    end
                end
                ST_INV_FIRST: state_q <= two_q ? ST_INV_LAST : ST_LOAD;
                ST_INV_LAST:  state_q <= ST_LOAD;
                ST_LOAD: begin
                    word_q  <= rf_rdata_i;
                    bsel_q  <= '0;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (mem_ready_i) begin
                        addr_q   <= addr_q + ADDR_W'(1);
                        remain_q <= remain_q - CNT_W'(1);
                        if (remain_q == CNT_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else if (bsel_q == BSEL_W'(WORD_BYTES - 1)) begin
                            src_q   <= (src_q == REG_W'(NREG - 1)) ? '0 : src_q + REG_W'(1);
                            state_q <= ST_LOAD;
                        end else begin
                            bsel_q <= bsel_q + BSEL_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        rf_raddr_o  = src_q;
        mem_valid_o = (state_q == ST_WRITE);
        mem_addr_o  = addr_q;
        mem_data_o  = lane_byte;
        inv_valid_o = (state_q == ST_INV_FIRST) || (state_q == ST_INV_LAST);
        inv_line_o  = (state_q == ST_INV_LAST) ? last_line_q : first_line_q;
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
    end
endmodule

// File: rtl/sss_string_store_chk.sv
// Module: protocol checker for the store-string sequencer, bound to the top.
// Assumes: the byte count is presented through cnt_i as the low bits of xer_i.
module sss_string_store_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_valid_o,
    input logic              mem_ready_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        mem_data_o,
    input logic              inv_valid_o
);
    logic              wrote_q;
    logic              have_prev_q;
    logic [ADDR_W-1:0] next_addr_q;

    // Track whether the current transfer has written and where the next byte goes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_q     <= 1'b0;
            have_prev_q <= 1'b0;
            next_addr_q <= '0;
        end else if (start_i && !busy_o) begin
            wrote_q     <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (mem_valid_o && mem_ready_i) begin
            wrote_q     <= 1'b1;
            have_prev_q <= 1'b1;
            next_addr_q <= mem_addr_o + ADDR_W'(1);
        end
    end

    p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && cnt_i == '0) |=> (done_o && !busy_o && !mem_valid_o && !inv_valid_o));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && have_prev_q) |-> (mem_addr_o == next_addr_q));

    p_inv_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid_o |-> (!wrote_q && !mem_valid_o));

    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

    p_busy_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (busy_o || done_o));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past((mem_valid_o && mem_ready_i) || (start_i && !busy_o))));
endmodule

bind sss_string_store sss_string_store_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cnt_i       (xer_i[CNT_W-1:0]),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .inv_valid_o (inv_valid_o)
);

// File: tb/test_sss_string_store.sv
// Bench: random and directed store-string transfers against a reference model.
module test_sss_string_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  src_idx = '0;
    logic [4:0]  base_idx = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [31:0] xer = '0;
    logic        resv_en = 1'b0;
    logic        resv_act = 1'b0;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_ready = 1'b1;
    logic        inv_valid;
    logic [31:0] inv_line;
    logic        busy;
    logic        done;

    logic [31:0] regs [32];
    assign rf_rdata = regs[rf_raddr];

    always #4 clk = ~clk;

    sss_string_store i_sss_string_store (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .src_idx_i (src_idx), .base_idx_i (base_idx), .base_val_i (base_val),
        .index_val_i (index_val), .xer_i (xer),
        .resv_en_i (resv_en), .resv_active_i (resv_act),
        .rf_raddr_o (rf_raddr), .rf_rdata_i (rf_rdata),
        .mem_valid_o (mem_valid), .mem_addr_o (mem_addr), .mem_data_o (mem_data),
        .mem_ready_i (mem_ready), .inv_valid_o (inv_valid), .inv_line_o (inv_line),
        .busy_o (busy), .done_o (done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic ready_rand = 1'b0;

    logic [31:0] w_addr [256];
    logic [7:0]  w_data [256];
    int          w_n = 0;
    logic [31:0] i_line [4];
    int          i_n = 0;
    int          first_w_t = -1;
    int          last_w_t = -1;
    int          last_i_t = -1;
    int          done_t = -1;
    int          done_cnt = 0;
    int          hold_err = 0;
    logic        pv = 1'b0;
    logic        pr = 1'b0;
    logic [31:0] pa = '0;
    logic [7:0]  pd = '0;

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Monitor and ready driver, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            finish_run();
        end
        if (pv && pr) begin
            if (w_n < 256) begin
                w_addr[w_n] = pa;
                w_data[w_n] = pd;
            end
            w_n++;
            if (first_w_t < 0) first_w_t = cyc;
            last_w_t = cyc;
        end
        if (pv && !pr && (!mem_valid || mem_addr != pa || mem_data != pd)) hold_err++;
        if (inv_valid) begin
            if (i_n < 4) i_line[i_n] = inv_line;
            i_n++;
            last_i_t = cyc;
        end
        if (done) begin
            done_cnt++;
            done_t = cyc;
        end
        mem_ready = ready_rand ? 1'($urandom % 2) : 1'b1;
        pv = mem_valid;
        pr = mem_ready;
        pa = mem_addr;
        pd = mem_data;
    end

    function automatic logic [7:0] exp_byte(input logic [4:0] src, input int i);
        logic [4:0]  r;
        logic [31:0] w;
        r = src + 5'(i / 4);
        w = regs[r];
        return w[8*(3 - (i % 4)) +: 8];
    endfunction

    // One transfer; intrude issues a second start while busy (R11).
    task automatic run_case(input logic [4:0] s, input logic [4:0] bi, input logic [31:0] bv,
                            input logic [31:0] iv, input logic [31:0] x, input logic en,
                            input logic act, input logic rnd, input logic intrude, input string tag);
        int nb;
        logic [31:0] ea;
        logic [31:0] fl;
        logic [31:0] ll;
        int exp_inv;
        int bad;
        int t;
        for (int k = 0; k < 32; k++) regs[k] = $urandom;
        nb = int'(x[6:0]);
        ea = iv + ((bi == 5'd0) ? 32'd0 : bv);
        fl = ea & 32'hFFFF_FF80;
        ll = (ea + 32'(nb) - 32'd1) & 32'hFFFF_FF80;
        exp_inv = (nb > 0 && en && act) ? ((fl != ll) ? 2 : 1) : 0;
        @(negedge clk);
        w_n = 0; i_n = 0; first_w_t = -1; last_w_t = -1; last_i_t = -1;
        done_t = -1; done_cnt = 0; hold_err = 0;
        ready_rand = rnd;
        src_idx = s; base_idx = bi; base_val = bv; index_val = iv; xer = x;
        resv_en = en; resv_act = act; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (nb == 0) begin
            check(done && !busy, "R2 done next cycle", {done, busy}, 2'b10);
        end else begin
            check(busy, "R2 busy after start", busy, 1);
        end
        if (intrude) begin
            repeat (3) @(negedge clk);
            src_idx = s + 5'd7; index_val = iv + 32'h100; xer = 32'h5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_t < 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        check(done_cnt == 1, "R12 single done pulse", done_cnt, 1);
        if (nb > 0)
            check(done_t == last_w_t, "R12 done after last write", done_t, last_w_t);
        check(w_n == nb, {tag, " byte count"}, w_n, nb);
        bad = -1;
        for (int k = 0; k < nb && k < w_n; k++)
            if (bad < 0 && w_data[k] != exp_byte(s, k)) bad = k;
        if (nb > 0)
            check(bad < 0, {tag, " R4 R5 byte data"}, (bad < 0) ? 0 : w_data[bad],
                  (bad < 0) ? 0 : exp_byte(s, bad));
        if (nb > 0 && w_n > 0)
            check(w_addr[0] == ea, "R3 first address", w_addr[0], ea);
        bad = -1;
        for (int k = 1; k < nb && k < w_n; k++)
            if (bad < 0 && w_addr[k] != ea + 32'(k)) bad = k;
        if (nb > 1)
            check(bad < 0, "R7 address step", (bad < 0) ? 0 : w_addr[bad],
                  (bad < 0) ? 0 : ea + 32'(bad));
        check(i_n == exp_inv, "R8 invalidation count", i_n, exp_inv);
        if (exp_inv >= 1 && i_n >= 1) check(i_line[0] == fl, "R8 first line", i_line[0], fl);
        if (exp_inv == 2 && i_n >= 2) check(i_line[1] == ll, "R8 last line", i_line[1], ll);
        if (i_n > 0 && w_n > 0)
            check(last_i_t < first_w_t, "R9 invalidate before write", last_i_t, first_w_t);
        if (rnd) check(hold_err == 0, "R10 stall hold", hold_err, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 32; k++) regs[k] = '0;
        repeat (4) @(negedge clk);
        check(!busy && !done && !mem_valid && !inv_valid, "reset outputs",
              {busy, done, mem_valid, inv_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "reset idle", {busy, done}, 0);

        run_case(5'd3, 5'd4, 32'h40, 32'h1000, 32'h0, 1, 1, 0, 0, "R2 zero");
        run_case(5'd1, 5'd2, 32'h10, 32'h2000, 32'hFFFF_FF85, 0, 0, 0, 0, "R1 upper xer");
        run_case(5'd9, 5'd0, 32'hDEAD_0000, 32'h3003, 32'd7, 0, 0, 1, 0, "R3 base zero");
        run_case(5'd30, 5'd5, 32'h0, 32'h4000, 32'd127, 1, 1, 1, 0, "R5 wrap 127");
        run_case(5'd0, 5'd6, 32'hFFFF_FFF0, 32'h0E, 32'd6, 1, 1, 1, 0, "R7 addr wrap");
        run_case(5'd2, 5'd6, 32'h100, 32'h0, 32'd10, 1, 1, 0, 0, "R8 one line");
        run_case(5'd2, 5'd6, 32'h178, 32'h0, 32'd10, 1, 0, 0, 0, "R8 no holders");
        run_case(5'd2, 5'd6, 32'h178, 32'h0, 32'd10, 0, 1, 0, 0, "R8 disabled");
        run_case(5'd4, 5'd7, 32'h200, 32'h5, 32'd1, 1, 1, 1, 0, "R6 single byte");
        run_case(5'd8, 5'd3, 32'h300, 32'h0, 32'd13, 0, 0, 1, 1, "R11 busy start");

        for (int n = 0; n < 40; n++)
            run_case(5'($urandom), 5'($urandom), $urandom, $urandom, $urandom,
                     1'($urandom), 1'($urandom), 1'($urandom), 1'b0, "R6 random");

        finish_run();
    end
endmodule